// File: doc/BRIEF.md
# Byte-Lane Write Merging RAM Front End

This block sits between a 64-bit bus and a single-port RAM of the same width. Reads return the whole stored doubleword. Writes carry one enable bit per byte lane. When every lane is enabled, the word goes straight into the RAM in one cycle. When only some lanes are enabled, the RAM cannot take the write directly. The block fetches the stored word, overlays the enabled bytes and stores the result.

The controller is a four-state machine. `S_IDLE` accepts requests and handles reads, full writes and empty writes. The transition `S_IDLE -> S_READ` is taken on a partial write. `S_READ -> S_MERGE` follows after the RAM read is issued. `S_MERGE -> S_WRITE` follows once the merged word is registered. `S_WRITE -> S_IDLE` follows after the write-back. While the machine is outside `S_IDLE`, `req_ready` is low, so the upstream bus holds its request until the sequence ends.

Top module: `rmw_mem_front`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read accepted in cycle T gives `rsp_valid` = 1 in cycle T+1, with the full stored 64-bit word on `rsp_rdata`.
- R3: A write with `req_lanes` = 8'hFF stores the whole word in one cycle. `rsp_valid` is 1 in the following cycle and `req_ready` stays 1.
- R4: A write with some lanes enabled and some clear changes only the enabled bytes, where lane i covers data bits [8i+7:8i]. For example, enabling lanes 1 and 2 leaves bytes 0 and 3 to 7 unchanged.
- R5: A partial write accepted in cycle T holds `req_ready` at 0 in cycles T+1 to T+3 (the states `S_READ`, `S_MERGE` and `S_WRITE`). In cycle T+4, `req_ready` is 1 and `rsp_valid` is 1. No response is given before then.
- R6: A write with `req_lanes` = 0 does not touch memory. It responds in the next cycle, and `req_ready` stays 1.
- R7: A read presented while a partial write is in progress is stalled for three cycles. It is then accepted and returns the merged word.
- R8: Reads and full writes can be accepted in consecutive cycles, with one response per request, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Doubleword address |
| req_wdata | input | 64 | Write data |
| req_lanes | input | 8 | Byte-lane enables; bit i enables bits [8i+7:8i] |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| rsp_valid | output | 1 | Completion of the request accepted in an earlier cycle |
| rsp_rdata | output | 64 | Read data, meaningful for read responses |

## Verification
Partial writes are tried with several lane masks: the two middle lanes, a single low lane, a single high lane, all lanes but one, and an alternating mask. Each mask is checked against a bench model of the word. Between them, these masks separate a correct byte merge from a shifted, inverted or lane-swapped one. A mask of all ones is used to tell the direct path apart from the merge path, and a mask of zeros is used to tell "no write" apart from "write zeros". A read queued behind a partial write shows whether the stall lasts long enough for the read to see the merged word.

// File: rtl/rmwfe_pkg.sv
package rmwfe_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_MERGE = 2'd2,
        S_WRITE = 2'd3
    } rmw_state_e;
endpackage

// File: rtl/rmwfe_ram.sv
module rmwfe_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/rmwfe_merge.sv
module rmwfe_merge #(
    parameter int DATA_W = 64,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              mrg_en,
    input  logic [DATA_W-1:0] new_data,
    input  logic [LANES-1:0]  new_lanes,
    input  logic [DATA_W-1:0] old_data,
    output logic [DATA_W-1:0] merged_q
);
    logic [DATA_W-1:0] hold_data;
    logic [LANES-1:0]  hold_lanes;
    logic [DATA_W-1:0] merged_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data  <= '0;
            hold_lanes <= '0;
        end else if (cap_en) begin
            hold_data  <= new_data;
            hold_lanes <= new_lanes;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged_d[8*i +: 8] = hold_lanes[i] ? hold_data[8*i +: 8]
                                                  : old_data[8*i +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merged_q <= '0;
        end else if (mrg_en) begin
            merged_q <= merged_d;
        end
    end
endmodule

// File: rtl/rmwfe_ctrl.sv
module rmwfe_ctrl
    import rmwfe_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_lanes,
    output logic             req_ready,
    output logic             ram_re,
    output logic             ram_we,
    output logic             use_hold,
    output logic             cap_en,
    output logic             mrg_en,
    output logic             rsp_valid,
    output rmw_state_e       state
);
    rmw_state_e state_nx;
    logic       rsp_set;
    logic       lanes_all;
    logic       lanes_none;

    assign lanes_all  = &req_lanes;
    assign lanes_none = ~|req_lanes;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            rsp_valid <= 1'b0;
        end else begin
            state     <= state_nx;
            rsp_valid <= rsp_set;
        end
    end

    always_comb begin
        state_nx  = state;
        req_ready = 1'b0;
        ram_re    = 1'b0;
        ram_we    = 1'b0;
        use_hold  = 1'b0;
        cap_en    = 1'b0;
        mrg_en    = 1'b0;
        rsp_set   = 1'b0;
        unique case (state)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (!req_write) begin
                        ram_re  = 1'b1;
                        rsp_set = 1'b1;
                    end else if (lanes_all) begin
                        ram_we  = 1'b1;
                        rsp_set = 1'b1;
                    end else if (lanes_none) begin
                        rsp_set = 1'b1;
                    end else begin
                        cap_en   = 1'b1;
                        state_nx = S_READ;
                    end
                end
            end
            S_READ: begin
                ram_re   = 1'b1;
                use_hold = 1'b1;
                state_nx = S_MERGE;
            end
            S_MERGE: begin
                mrg_en   = 1'b1;
                state_nx = S_WRITE;
            end
            S_WRITE: begin
                ram_we   = 1'b1;
                use_hold = 1'b1;
                rsp_set  = 1'b1;
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end
endmodule

// File: rtl/rmw_mem_front.sv
module rmw_mem_front
    import rmwfe_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_lanes,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata
);
    localparam int LANES = DATA_W / 8;

    logic              ram_re;
    logic              ram_we;
    logic              use_hold;
    logic              cap_en;
    logic              mrg_en;
    rmw_state_e        state;
    logic [ADDR_W-1:0] hold_addr;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] merged_q;

    rmwfe_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_lanes (req_lanes),
        .req_ready (req_ready),
        .ram_re    (ram_re),
        .ram_we    (ram_we),
        .use_hold  (use_hold),
        .cap_en    (cap_en),
        .mrg_en    (mrg_en),
        .rsp_valid (rsp_valid),
        .state     (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
        end else if (cap_en) begin
            hold_addr <= req_addr;
        end
    end

    assign ram_addr  = use_hold ? hold_addr : req_addr;
    assign ram_wdata = use_hold ? merged_q  : req_wdata;

    rmwfe_merge #(.DATA_W(DATA_W), .LANES(LANES)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .mrg_en    (mrg_en),
        .new_data  (req_wdata),
        .new_lanes (req_lanes),
        .old_data  (ram_rdata),
        .merged_q  (merged_q)
    );

    rmwfe_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .re    (ram_re),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign rsp_rdata = ram_rdata;
endmodule

// File: rtl/rmwfe_checker.sv
module rmwfe_checker
    import rmwfe_pkg::*;
#(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [LANES-1:0] req_lanes,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             ram_we,
    input rmw_state_e       state
);
    logic acc;
    logic part;
    assign acc  = req_valid && req_ready;
    assign part = (|req_lanes) && !(&req_lanes);

    // R2
    p_read_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write) |=> rsp_valid);

    // R3
    p_full_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && (&req_lanes)) |=> (rsp_valid && req_ready));

    // R5
    p_rmw_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && part) |=> !req_ready ##1 !req_ready ##1 !req_ready
                                       ##1 (req_ready && rsp_valid));

    // R5
    p_rmw_norsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && part) |=> !rsp_valid ##1 !rsp_valid ##1 !rsp_valid);

    // R5: write-back only from the final sequence state or a direct full write
    p_we_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (state == S_WRITE || (acc && req_write && (&req_lanes))));

    // R6
    p_zero_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && (req_lanes == '0)) |-> !ram_we);

    // R6
    p_zero_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && (req_lanes == '0)) |=> (rsp_valid && req_ready));
endmodule

bind rmw_mem_front rmwfe_checker #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_lanes (req_lanes),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ram_we    (ram_we),
    .state     (state)
);

// File: tb/rmw_mem_front_test.sv
`timescale 1ns/1ps
module rmw_mem_front_test;
    localparam int AW = 6;
    localparam int DW = 64;
    localparam int LN = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [LN-1:0] req_lanes = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] model [1 << AW];

    always #10 clk = ~clk;

    rmw_mem_front #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present a request at a negedge, wait for ready, return at the negedge after acceptance.
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [LN-1:0] ln, output int waits);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln;
        waits = 0;
        while (!req_ready) begin
            @(negedge clk);
            waits++;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] merge_ref(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                                 input logic [LN-1:0] ln);
        logic [DW-1:0] r = o;
        for (int i = 0; i < LN; i++) if (ln[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    task automatic read_check(input logic [AW-1:0] a, input string tag);
        int w;
        issue(1'b0, a, '0, '0, w);
        check(rsp_valid === 1'b1, {tag, " rsp_valid"}, DW'(rsp_valid), 1);
        check(rsp_rdata === model[a], {tag, " rdata"}, rsp_rdata, model[a]);
    endtask

    task automatic t_reset;
        check(req_ready === 1'b1, "R1 ready", DW'(req_ready), 1);
        check(rsp_valid === 1'b0, "R1 rsp_valid", DW'(rsp_valid), 0);
    endtask

    task automatic t_full_writes;
        int w;
        for (int k = 0; k < 8; k++) begin
            logic [DW-1:0] d = 64'h0123_4567_89AB_CDEF ^ {8{8'(k * 17)}};
            issue(1'b1, AW'(k), d, 8'hFF, w);
            model[k] = d;
            check(rsp_valid === 1'b1, "R3 rsp next cycle", DW'(rsp_valid), 1);
            check(req_ready === 1'b1, "R3 ready stays high", DW'(req_ready), 1);
        end
        for (int k = 0; k < 8; k++) read_check(AW'(k), "R2 R3 readback");
    endtask

    task automatic t_partial(input logic [AW-1:0] a, input logic [LN-1:0] ln);
        int w;
        logic [DW-1:0] d = 64'hA5C3_0F1E_77D2_9B48 ^ {8{8'(ln)}};
        issue(1'b1, a, d, ln, w);
        model[a] = merge_ref(model[a], d, ln);
        for (int c = 1; c <= 3; c++) begin
            check(req_ready === 1'b0, "R5 ready low in sequence", DW'(req_ready), 0);
            check(rsp_valid === 1'b0, "R5 no early rsp", DW'(rsp_valid), 0);
            @(negedge clk);
        end
        check(req_ready === 1'b1, "R5 ready back", DW'(req_ready), 1);
        check(rsp_valid === 1'b1, "R5 rsp after write-back", DW'(rsp_valid), 1);
        @(negedge clk);
        read_check(a, "R4 merged bytes");
    endtask

    task automatic t_zero;
        int w;
        issue(1'b1, 6'd3, 64'hDEAD_BEEF_DEAD_BEEF, 8'h00, w);
        check(rsp_valid === 1'b1, "R6 rsp next cycle", DW'(rsp_valid), 1);
        check(req_ready === 1'b1, "R6 ready high", DW'(req_ready), 1);
        read_check(6'd3, "R6 memory unchanged");
    endtask

    task automatic t_stalled_read;
        int w;
        logic [DW-1:0] d = 64'h1122_3344_5566_7788;
        issue(1'b1, 6'd6, d, 8'h3C, w);
        model[6] = merge_ref(model[6], d, 8'h3C);
        issue(1'b0, 6'd6, '0, '0, w);
        check(w == 3, "R7 stall cycles", DW'(w), 3);
        check(rsp_valid === 1'b1, "R7 rsp_valid", DW'(rsp_valid), 1);
        check(rsp_rdata === model[6], "R7 read sees merge", rsp_rdata, model[6]);
    endtask

    task automatic t_back_to_back;
        logic [DW-1:0] d0 = 64'hFEED_FACE_CAFE_0001;
        logic [DW-1:0] d1 = 64'hFEED_FACE_CAFE_0002;
        req_valid = 1'b1; req_write = 1'b1; req_lanes = 8'hFF;
        req_addr = 6'd10; req_wdata = d0;
        @(posedge clk); @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b1, "R8 first write", DW'(rsp_valid), 1);
        req_addr = 6'd11; req_wdata = d1;
        @(posedge clk); @(negedge clk);
        check(rsp_valid === 1'b1, "R8 second write", DW'(rsp_valid), 1);
        req_write = 1'b0; req_addr = 6'd10;
        @(posedge clk); @(negedge clk);
        check(rsp_rdata === d0, "R8 first read", rsp_rdata, d0);
        req_addr = 6'd11;
        @(posedge clk); @(negedge clk);
        check(rsp_rdata === d1, "R8 second read", rsp_rdata, d1);
        req_valid = 1'b0;
        model[10] = d0; model[11] = d1;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_full_writes;
        t_partial(6'd5, 8'h06);
        t_partial(6'd1, 8'h01);
        t_partial(6'd2, 8'h80);
        t_partial(6'd4, 8'hFE);
        t_partial(6'd7, 8'h55);
        t_zero;
        t_stalled_read;
        t_back_to_back;
        @(negedge clk);
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run;
    end
endmodule